// File: doc/BRIEF.md
# Retriggerable Dual-Compare Timer

A 16-bit up-counting timer with one input pin and one output pin. A control word picks the counting mode. The count source is either the internal clock (through an optional prescaler) or rising edges on the input pin. The input pin can also act as a level gate or as a restart trigger. The timer runs against one compare value or alternates between two. It stops after one pass or keeps running.

In single-compare mode the output idles high and drops low for one clock each time the count reaches the end of its cycle. In dual-compare mode the output is a level that shows which of the two compare values is currently in use. This gives a waveform with a programmable high time and low time.

The input pin passes through a two-flop synchronizer before any decoding. A restart edge zeroes the count but keeps the compare value that is currently in use.

Top module: `rtrig_timer`

## Requirements
- R1: After reset, `count` is 0, `tmr_out` is 1, `riu` is 0 and `enabled` is 0.
- R2: When `ctl_wr` is high at a clock edge, the five control bits are loaded from `ctl_en`, `ctl_ext`, `ctl_rtg`, `ctl_dual` and `ctl_cont`. That same edge clears `count`, `riu` and the restart-armed state, and sets `tmr_out` high.
- R3: With `ctl_ext`=0 and `ctl_rtg`=0, `count` advances by one per internal event only while the synchronized input is high. A level on `tmr_in` reaches the synchronized value two clock edges after it is applied.
- R4: With `ctl_ext`=0 and `ctl_rtg`=1, the count does not advance after enabling until the first synchronized rising edge on `tmr_in`. Every such edge sets `count` to 0 and restarts the cycle.
- R5: A restart edge never changes `riu`. When a restart edge and a terminal count fall in the same cycle, the restart wins: `count` becomes 0, no output pulse occurs and `riu` keeps its value.
- R6: With `ctl_ext`=1, each synchronized rising edge of `tmr_in` advances `count` by one, and `ctl_rtg` has no effect.
- R7: In single mode (`ctl_dual`=0), an event that would take the count to `cmp_a` is a terminal count. It returns `count` to 0 and drives `tmr_out` low for the one clock that follows. In continuous mode this repeats every `cmp_a` events, so a value of 1 holds the output low.
- R8: In dual mode, the active compare value is `cmp_a` while `riu`=0 and `cmp_b` while `riu`=1. `riu` toggles at each terminal count, and `tmr_out` equals the inverse of `riu`.
- R9: In one-shot mode (`ctl_cont`=0), `enabled` clears at the terminal count. In single mode this is the first terminal count; in dual mode it is the terminal count taken while `riu`=1. After that, `count` stays at 0.
- R10: A compare value of 0 stands for 65536 events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Load control bits and restart the timer |
| ctl_en | input | 1 | Enable value to load |
| ctl_ext | input | 1 | 1: input pin is the count clock |
| ctl_rtg | input | 1 | 1: input rising edge restarts the count (when ctl_ext=0) |
| ctl_dual | input | 1 | 1: alternate between two compare values |
| ctl_cont | input | 1 | 1: run continuously, 0: one-shot |
| cmp_a | input | 16 | First compare value (0 means 65536) |
| cmp_b | input | 16 | Second compare value (0 means 65536) |
| tmr_in | input | 1 | Asynchronous timer input pin |
| tmr_out | output | 1 | Timer output pin |
| riu | output | 1 | Compare value in use (0: A, 1: B) |
| count | output | 16 | Current count |
| enabled | output | 1 | Enable bit state |

## Verification
A restart edge can reach the counter in the same cycle as the event that would end the cycle. The bench provokes this in dual mode with short compare values. It arms the timer, then slides a second input pulse over a range of offsets, so that across the sweep the restart falls on the terminal cycle and on the cycles on both sides of it. On every clock the bench compares `count`, `tmr_out`, `riu` and `enabled` with an arithmetic model. A collision is judged correct only if the count returns to zero with no output edge and `riu` unchanged.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  typedef struct packed {
    logic en;
    logic ext;
    logic rtg;
    logic dual;
    logic cont;
  } rtt_ctl_t;
endpackage

// File: rtl/rtt_insync.sv
module rtt_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic lvl,
  output logic rise
);
  logic [STAGES:0] sh;

  generate
    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sh[0] <= 1'b0;
          else     sh[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sh[i] <= 1'b0;
          else     sh[i] <= sh[i-1];
        end
      end
    end
  endgenerate

  assign lvl  = sh[STAGES-1];
  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/rtt_prescale.sv
module rtt_prescale #(
  parameter int DIV = 1
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pc;

  always_ff @(posedge clk) begin
    if (rst || pc == LAST) pc <= '0;
    else                   pc <= pc + 1'b1;
  end

  assign tick = (pc == LAST);
endmodule

// File: rtl/rtt_core.sv
module rtt_core
  import rtt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_wr,
  input  rtt_ctl_t      ctl_in,
  input  logic [CW-1:0] cmp_a,
  input  logic [CW-1:0] cmp_b,
  input  logic          tick,
  input  logic          lvl,
  input  logic          rise,
  output rtt_ctl_t      ctl_q,
  output logic [CW-1:0] cnt_q,
  output logic          riu_q,
  output logic          out_q
);
  localparam logic [CW:0] FULL = {1'b1, {CW{1'b0}}};
  localparam logic [CW:0] ONE  = (CW+1)'(1);

  logic          armed_q;
  logic [CW-1:0] act_max;
  logic [CW:0]   lim;
  logic [CW:0]   nxt;
  logic          retrig, evt, hit, riu_nx, stop;

  always_comb begin
    act_max = (ctl_q.dual && riu_q) ? cmp_b : cmp_a;
    lim     = (act_max == '0) ? FULL : {1'b0, act_max};
    nxt     = {1'b0, cnt_q} + ONE;
    retrig  = ctl_q.en && !ctl_q.ext && ctl_q.rtg && rise;
    if (!ctl_q.en || retrig)  evt = 1'b0;
    else if (ctl_q.ext)       evt = rise;
    else if (ctl_q.rtg)       evt = armed_q && tick;
    else                      evt = lvl && tick;
    hit    = evt && (nxt == lim);
    riu_nx = riu_q ^ (hit && ctl_q.dual);
    stop   = hit && !ctl_q.cont && (!ctl_q.dual || riu_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      cnt_q   <= '0;
      riu_q   <= 1'b0;
      armed_q <= 1'b0;
      out_q   <= 1'b1;
    end else if (ctl_wr) begin
      ctl_q   <= ctl_in;
      cnt_q   <= '0;
      riu_q   <= 1'b0;
      armed_q <= 1'b0;
      out_q   <= 1'b1;
    end else begin
      if (retrig) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (hit) begin
        cnt_q <= '0;
      end else if (evt) begin
        cnt_q <= nxt[CW-1:0];
      end
      riu_q <= riu_nx;
      if (stop) ctl_q.en <= 1'b0;
      out_q <= ctl_q.dual ? ~riu_nx : ~hit;
    end
  end
endmodule

// File: rtl/rtrig_timer.sv
module rtrig_timer
  import rtt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRESCALE    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic             ctl_en,
  input  logic             ctl_ext,
  input  logic             ctl_rtg,
  input  logic             ctl_dual,
  input  logic             ctl_cont,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic             tmr_in,
  output logic             tmr_out,
  output logic             riu,
  output logic [CNT_W-1:0] count,
  output logic             enabled
);
  rtt_ctl_t ctl_in, ctl_q;
  logic     pin_lvl, pin_rise, evt_tick;

  assign ctl_in = '{en: ctl_en, ext: ctl_ext, rtg: ctl_rtg,
                    dual: ctl_dual, cont: ctl_cont};

  rtt_insync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(tmr_in), .lvl(pin_lvl), .rise(pin_rise)
  );

  rtt_prescale #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .tick(evt_tick)
  );

  rtt_core #(.CW(CNT_W)) u_core (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_in(ctl_in),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .tick(evt_tick),
    .lvl(pin_lvl), .rise(pin_rise),
    .ctl_q(ctl_q), .cnt_q(count), .riu_q(riu), .out_q(tmr_out)
  );

  assign enabled = ctl_q.en;
endmodule

// File: rtl/rtt_timer_chk.sv
module rtt_timer_chk
  import rtt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ctl_wr,
  input rtt_ctl_t         ctl,
  input logic             lvl,
  input logic             tmr_out,
  input logic             riu,
  input logic [CNT_W-1:0] count
);
  // R3/R4/R6: the count only holds, steps by one, or returns to zero
  a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
    !$past(ctl_wr) |-> (count == $past(count) || count == $past(count) + 1'b1 || count == '0));

  // R3: gate low freezes the count
  a_r3_gate_hold: assert property (@(posedge clk) disable iff (rst)
    (ctl.en && !ctl.ext && !ctl.rtg && !lvl && !ctl_wr) |=> count == $past(count));

  // R7: a low output in single mode only follows a wrap to zero
  a_r7_pulse_at_zero: assert property (@(posedge clk) disable iff (rst)
    (!ctl.dual && !tmr_out) |-> count == '0);

  // R8: dual-mode output level tracks the compare in use
  a_r8_level_tracks_riu: assert property (@(posedge clk) disable iff (rst)
    ctl.dual |-> tmr_out == !riu);

  // R5/R8: riu only moves together with a wrap
  a_r5_riu_on_wrap: assert property (@(posedge clk) disable iff (rst)
    (!$stable(riu) && !$past(ctl_wr)) |-> count == '0);

  // R9: enable clears by itself only in one-shot mode
  a_r9_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
    ($fell(ctl.en) && !$past(ctl_wr)) |-> (!$past(ctl.cont) && count == '0));
endmodule

bind rtrig_timer rtt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl(ctl_q), .lvl(pin_lvl),
  .tmr_out(tmr_out), .riu(riu), .count(count)
);

// File: tb/test_rtrig_timer.sv
module test_rtrig_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_wr = 1'b0;
  logic        c_en = 0, c_ext = 0, c_rtg = 0, c_dual = 0, c_cont = 0;
  logic [15:0] cmp_a = 16'd0, cmp_b = 16'd0;
  logic        tmr_in = 1'b0;
  logic        tmr_out, riu, enabled;
  logic [15:0] count;

  int checks = 0, failures = 0, cycles = 0;
  string cur_req = "R1";

  // Arithmetic model state
  int   m_cnt;
  logic m_en, m_ext, m_rtg, m_dual, m_cont, m_riu, m_arm, m_out;
  logic p1, p2, p3;

  always #10 clk = ~clk;

  rtrig_timer i_rtrig_timer (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_en(c_en), .ctl_ext(c_ext),
    .ctl_rtg(c_rtg), .ctl_dual(c_dual), .ctl_cont(c_cont),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .tmr_in(tmr_in),
    .tmr_out(tmr_out), .riu(riu), .count(count), .enabled(enabled)
  );

  always @(posedge clk) begin
    logic r, ev, term;
    int lim;
    r = p2 & ~p3;
    term = 1'b0;
    if (rst) begin
      m_cnt = 0; m_en = 0; m_ext = 0; m_rtg = 0; m_dual = 0; m_cont = 0;
      m_riu = 0; m_arm = 0; m_out = 1;
      p1 = 0; p2 = 0; p3 = 0;
    end else begin
      if (ctl_wr) begin
        m_en = c_en; m_ext = c_ext; m_rtg = c_rtg; m_dual = c_dual; m_cont = c_cont;
        m_cnt = 0; m_riu = 0; m_arm = 0; m_out = 1;
      end else begin
        if (m_en && !m_ext && m_rtg && r) begin
          m_cnt = 0; m_arm = 1;
        end else begin
          ev = m_en && (m_ext ? r : (m_rtg ? m_arm : p2));
          if (ev) begin
            lim = (m_dual && m_riu) ? int'(cmp_b) : int'(cmp_a);
            if (lim == 0) lim = 65536;
            if (m_cnt + 1 == lim) begin m_cnt = 0; term = 1; end
            else m_cnt = m_cnt + 1;
          end
        end
        if (term) begin
          if (!m_cont && (!m_dual || m_riu)) m_en = 0;
          if (m_dual) m_riu = ~m_riu;
        end
        m_out = m_dual ? ~m_riu : ~term;
      end
      p3 = p2; p2 = p1; p1 = tmr_in;
    end
  end

  task automatic compare();
    logic [18:0] act, exp;
    act = {count, tmr_out, riu, enabled};
    exp = {m_cnt[15:0], m_out, m_riu, m_en};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s cycle=%0d act={cnt=%0d out=%b riu=%b en=%b} exp={cnt=%0d out=%b riu=%b en=%b}",
               cur_req, cycles, act[18:3], act[2], act[1], act[0],
               exp[18:3], exp[2], exp[1], exp[0]);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      compare();
    end
  endtask

  task automatic wr(logic en, logic ext, logic rtg, logic dual, logic cont,
                    int a, int b);
    string keep;
    keep = cur_req;
    cur_req = "R2";
    c_en = en; c_ext = ext; c_rtg = rtg; c_dual = dual; c_cont = cont;
    cmp_a = 16'(a); cmp_b = 16'(b);
    ctl_wr = 1'b1;
    step(1);
    ctl_wr = 1'b0;
    cur_req = keep;
  endtask

  task automatic quiet_pin();
    tmr_in = 1'b0;
    wr(0, 0, 0, 0, 0, 1, 1);
    step(4);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    step(2);
    rst = 1'b0;
    cur_req = "R1";
    step(1);

    // R7: single continuous, gate held high, sweep compare values
    cur_req = "R7";
    tmr_in = 1'b1;
    step(3);
    for (int n = 1; n <= 6; n++) begin
      wr(1, 0, 0, 0, 1, n, 0);
      step(3 * n + 2);
    end

    // R3: gate mode with a varying input level
    cur_req = "R3";
    wr(1, 0, 0, 0, 1, 4, 0);
    for (int i = 0; i < 60; i++) begin
      tmr_in = ((i % 7) < 4);
      step(1);
    end

    // R4: retrigger mode waits for first edge, later edges restart
    quiet_pin();
    cur_req = "R4";
    wr(1, 0, 1, 0, 1, 5, 0);
    step(10);
    tmr_in = 1'b1; step(1); tmr_in = 1'b0;
    step(8);
    tmr_in = 1'b1; step(1); tmr_in = 1'b0;
    step(12);

    // R5: retrigger colliding with terminal count in dual mode
    cur_req = "R5";
    for (int o = 0; o <= 12; o++) begin
      quiet_pin();
      wr(1, 0, 1, 1, 1, 3, 4);
      tmr_in = 1'b1; step(1); tmr_in = 1'b0;
      step(o + 1);
      tmr_in = 1'b1; step(1); tmr_in = 1'b0;
      step(16);
    end

    // R6: external clock, retrigger bit set but ignored
    quiet_pin();
    cur_req = "R6";
    wr(1, 1, 1, 0, 1, 3, 0);
    for (int i = 0; i < 48; i++) begin
      tmr_in = ((i % 4) < 2);
      step(1);
    end

    // R8: dual continuous level output
    quiet_pin();
    cur_req = "R8";
    tmr_in = 1'b1;
    step(3);
    wr(1, 0, 0, 1, 1, 2, 3);
    step(30);

    // R9: one-shot single and dual
    cur_req = "R9";
    wr(1, 0, 0, 0, 0, 3, 0);
    step(12);
    wr(1, 0, 0, 1, 0, 2, 2);
    step(14);

    // R10: compare value 0 means 65536 events
    cur_req = "R10";
    wr(1, 0, 0, 0, 1, 0, 0);
    step(65540);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule